// File: doc/BRIEF.md
# Done-Queue Write Coalescing Cache

This block sits between a DMA engine that produces completion entries and the host's circular done queue. Entries arrive on a valid/ready stream. Each entry is a 32-bit word that the block forwards without changing any bit: bits 15-0 hold the descriptor pointer, bits 23-16 hold the channel number, and the upper bits hold status (bits 28-26 on the transmit side). Entries are held in a small internal cache. They leave as bursts of done-queue writes on a second valid/ready stream. A burst starts when the cache reaches a programmable high watermark or when a flush timer expires, whichever happens first. The flush timer bounds how long the oldest cached entry can wait. It is loaded while the cache is empty and counts down from the moment the first entry lands. After reset the cache is disabled, and in that state every entry is written through on its own, one at a time.

The block owns the queue's write pointer and compares it with a read pointer that the host writes. The host also programs the queue's last index and its base address. A burst never writes into the last free slot, so the queue is never overfilled. When the queue has no room, the writes stall, entries stay in the cache, and once the cache is full the input stream is held off. No entry is ever dropped. A done flag and the interrupt are raised once for every programmable number of completed write bursts, not once per burst.

Back-pressure rules:
- The input is accepted on a cycle where `ent_valid` and `ent_ready` are both high. `ent_ready` is low only while the cache is full.
- On the output, `wr_valid`, `wr_addr`, `wr_data` and `wr_last` stay steady until `wr_ready` is seen high.
- `wr_last` marks the final word of each burst.

Top module: `dq_coalesce`

Host registers (word index on `reg_addr`):
- 0, control: bit 0 enables the cache; bits 7-4 set the high watermark in entries; bits 10-8 set the event threshold.
- 1, queue base byte address.
- 2, last index.
- 3, host read pointer.
- 4, read only: bits 7-0 hold the write pointer and bits 31-16 hold the occupancy.
- 5, flush reload value.
- 6, status: bit 0 is the done flag; writing 1 to it clears the flag.

## Requirements
- R1: After reset the cache is disabled, `ent_ready` is 1, `wr_valid` is 0, `irq` is 0, the write pointer reads 0 and the flush reload reads 0x1000.
- R2: With control bit 0 clear, every accepted entry produces exactly one write with `wr_last` = 1. The entries leave in arrival order and their data is unchanged.
- R3: With the cache enabled and a high watermark of H, no write is issued while fewer than H entries are cached and the timer has not expired. When the H-th entry arrives, one burst carries all H entries, and `wr_last` is set only on the final word.
- R4: With the cache enabled, fewer than H cached entries are written once the flush timer, loaded with the reload value, has counted down after the first entry entered the empty cache. No write is issued well before that point.
- R5: Each write goes to base + 4 × write pointer. After each write the pointer steps by one and wraps to 0 after it reaches the last index.
- R6: A write is issued only while free slots (last index − occupancy) is non-zero. When the queue is full, writes stall until the host advances the read pointer.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, the valid, address and data outputs hold their values.
- R8: `ent_ready` is 0 exactly when the cache holds DEPTH entries. Every accepted entry is eventually written, so none is lost.
- R9: Occupancy reads as write pointer − read pointer when write ≥ read. Otherwise it reads as last index + 1 − read + write.
- R10: With an event threshold of T, the done flag and `irq` rise after T+1 completed bursts, counted from the last control write. Writing 1 to status bit 0 clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | Completion entry offered |
| ent_ready | output | 1 | Cache can take an entry |
| ent_data | input | DW | Completion entry word |
| wr_valid | output | 1 | Done-queue write offered |
| wr_ready | input | 1 | Host side takes the write |
| wr_addr | output | AW | Byte address of the write |
| wr_data | output | DW | Entry word being written |
| wr_last | output | 1 | Final word of a burst |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register word index |
| reg_wdata | input | 32 | Host register write data |
| reg_rdata | output | 32 | Host register read data (combinational) |
| irq | output | 1 | Done flag interrupt |

## Verification
The bench targets the following corner cases:
- A tiny queue whose last index is 3. It fills, stalls with entries still cached, takes more entries until the cache is full, and then resumes across the wrap. A design that miscounts free slots would overwrite unread entries. A design with a wrong wrap would write past the last index. Either error shows up as a wrong address in the scoreboard.
- The read-pointer-above-write-pointer branch of the occupancy formula.
- A watermark one entry short of its trigger, and a sub-watermark group that only the timer can release. Flushing early, or never, is caught by checking the write count on both sides of the trigger point.
- Output back-pressure and the exact burst count for the done flag. A flag that fires one burst early or late fails there.

// File: rtl/dqc_pkg.sv
package dqc_pkg;
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_BASE   = 3'd1,
    RA_END    = 3'd2,
    RA_RDPTR  = 3'd3,
    RA_WRPTR  = 3'd4,
    RA_RELOAD = 3'd5,
    RA_STATUS = 3'd6
  } reg_addr_e;

  typedef enum logic {
    ST_IDLE,
    ST_BURST
  } burst_st_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_HWM_LSB = 4;
  localparam int CTRL_THR_LSB = 8;
  localparam int THR_W        = 3;
  localparam int OCC_LSB      = 16;
endpackage

// File: rtl/dqc_entry_cache.sv
module dqc_entry_cache #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [DW-1:0] slots [DEPTH];
  logic [PW-1:0] wr_idx, rd_idx;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_idx] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= step(wr_idx);
      if (pop)  rd_idx <= step(rd_idx);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = slots[rd_idx];
  assign full = (count == CW'(DEPTH));

  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/dqc_flush_timer.sv
module dqc_flush_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             occupied,
  input  logic [TMR_W-1:0] reload,
  output logic             expired
);
  logic [TMR_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                  remain <= '0;
    else if (!enable || !occupied) remain <= reload;
    else if (remain != '0)       remain <= remain - 1'b1;
  end

  assign expired = enable && occupied && (remain == '0);
endmodule

// File: rtl/dqc_ring_ptr.sv
module dqc_ring_ptr #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] end_idx,
  input  logic [IDX_W-1:0] rd_ptr,
  input  logic             advance,
  output logic [IDX_W-1:0] wr_ptr,
  output logic [IDX_W-1:0] occ,
  output logic [IDX_W-1:0] free
);
  always_ff @(posedge clk) begin
    if (!rst_n)       wr_ptr <= '0;
    else if (advance) wr_ptr <= (wr_ptr == end_idx) ? '0 : wr_ptr + 1'b1;
  end

  always_comb begin
    if (wr_ptr >= rd_ptr) occ = wr_ptr - rd_ptr;
    else                  occ = end_idx + 1'b1 - rd_ptr + wr_ptr;
  end

  assign free = end_idx - occ;

  // R6
  no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> free != '0);
endmodule

// File: rtl/dq_coalesce.sv
module dq_coalesce
  import dqc_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int IDX_W      = 8,
  parameter int DEPTH      = 8,
  parameter int TMR_W      = 16,
  parameter int RELOAD_RST = 'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ent_valid,
  output logic          ent_ready,
  input  logic [DW-1:0] ent_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_last,
  input  logic          reg_wr_en,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic             cache_en;
  logic [CW-1:0]    hwm;
  logic [THR_W-1:0] thr, ev_cnt;
  logic [AW-1:0]    base;
  logic [IDX_W-1:0] end_idx, rd_ptr, wr_ptr, occ, free;
  logic [TMR_W-1:0] reload;
  logic             done_flag;

  logic             push, pop, full, expired, fire, burst_done, start;
  logic [CW-1:0]    count, remain, burst_len;
  logic [DW-1:0]    head;
  burst_st_e        state;

  wire wr_ctrl = reg_wr_en && (reg_addr == RA_CTRL);

  // host register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_en <= 1'b0;
      hwm      <= CW'(DEPTH);
      thr      <= '0;
      base     <= '0;
      end_idx  <= '1;
      rd_ptr   <= '0;
      reload   <= TMR_W'(RELOAD_RST);
    end else if (reg_wr_en) begin
      case (reg_addr)
        RA_CTRL: begin
          cache_en <= reg_wdata[CTRL_EN_BIT];
          hwm      <= reg_wdata[CTRL_HWM_LSB +: CW];
          thr      <= reg_wdata[CTRL_THR_LSB +: THR_W];
        end
        RA_BASE:   base    <= reg_wdata[AW-1:0];
        RA_END:    end_idx <= reg_wdata[IDX_W-1:0];
        RA_RDPTR:  rd_ptr  <= reg_wdata[IDX_W-1:0];
        RA_RELOAD: reload  <= reg_wdata[TMR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata[CTRL_EN_BIT]              = cache_en;
        reg_rdata[CTRL_HWM_LSB +: CW]       = hwm;
        reg_rdata[CTRL_THR_LSB +: THR_W]    = thr;
      end
      RA_BASE:   reg_rdata[AW-1:0]    = base;
      RA_END:    reg_rdata[IDX_W-1:0] = end_idx;
      RA_RDPTR:  reg_rdata[IDX_W-1:0] = rd_ptr;
      RA_WRPTR: begin
        reg_rdata[IDX_W-1:0]        = wr_ptr;
        reg_rdata[OCC_LSB +: IDX_W] = occ;
      end
      RA_RELOAD: reg_rdata[TMR_W-1:0] = reload;
      RA_STATUS: reg_rdata[0]         = done_flag;
      default: ;
    endcase
  end

  assign ent_ready = !full;
  assign push      = ent_valid && !full;

  dqc_entry_cache #(.DW(DW), .DEPTH(DEPTH)) u_cache (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(ent_data),
    .pop(pop), .head(head), .count(count), .full(full)
  );

  dqc_flush_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(cache_en), .occupied(count != '0),
    .reload(reload), .expired(expired)
  );

  dqc_ring_ptr #(.IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .end_idx(end_idx), .rd_ptr(rd_ptr),
    .advance(fire), .wr_ptr(wr_ptr), .occ(occ), .free(free)
  );

  // burst sizing and start decision
  always_comb begin
    if (!cache_en)                   burst_len = CW'(1);
    else if (32'(count) <= 32'(free)) burst_len = count;
    else                             burst_len = CW'(free);
  end

  assign start = (state == ST_IDLE) && (count != '0) && (free != '0) &&
                 (!cache_en || (count >= hwm) || expired);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else if (start) begin
      state  <= ST_BURST;
      remain <= burst_len;
    end else if (fire) begin
      remain <= remain - 1'b1;
      if (remain == CW'(1)) state <= ST_IDLE;
    end
  end

  assign wr_valid   = (state == ST_BURST);
  assign fire       = wr_valid && wr_ready;
  assign pop        = fire;
  assign burst_done = fire && (remain == CW'(1));
  assign wr_data    = head;
  assign wr_last    = wr_valid && (remain == CW'(1));
  assign wr_addr    = base + (AW'(wr_ptr) << 2);

  // write-event threshold and done flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_cnt    <= '0;
      done_flag <= 1'b0;
    end else begin
      if (wr_ctrl)                               ev_cnt <= '0;
      else if (burst_done && ev_cnt == thr)      ev_cnt <= '0;
      else if (burst_done)                       ev_cnt <= ev_cnt + 1'b1;

      if (burst_done && !wr_ctrl && ev_cnt == thr) done_flag <= 1'b1;
      else if (reg_wr_en && reg_addr == RA_STATUS && reg_wdata[0])
        done_flag <= 1'b0;
    end
  end

  assign irq = done_flag;

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr));
  // R2
  single_word_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_en && wr_valid |-> wr_last);
  // R10
  flag_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(burst_done));
endmodule

// File: tb/dq_coalesce_test.sv
module dq_coalesce_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ent_valid = 1'b0, ent_ready;
  logic [31:0] ent_data = '0;
  logic        wr_valid, wr_ready = 1'b1, wr_last;
  logic [31:0] wr_addr, wr_data;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq;

  always #10 clk = ~clk;

  dq_coalesce uut (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_data(ent_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_last(wr_last),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int errors = 0, checks = 0;
  int writes_seen = 0, lasts_seen = 0;
  logic [31:0] exp_q[$];
  logic [31:0] m_base = '0;
  logic [7:0]  m_end = 8'hFF, m_wp = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 3'd1) m_base = d;
    if (a == 3'd2) m_end  = d[7:0];
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // driver: offers one entry, records it once accepted
  task automatic push(input logic [31:0] d);
    ent_valid = 1'b1; ent_data = d;
    while (!ent_ready) @(negedge clk);
    exp_q.push_back(d);
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard for data order (R2) and addressing (R5)
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      writes_seen++;
      if (wr_last) lasts_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected write", wr_data, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(wr_data == e, "R2", "entry data/order", wr_data, e);
        chk(wr_addr == m_base + {22'd0, m_wp, 2'b00}, "R5", "write address",
            wr_addr, m_base + {22'd0, m_wp, 2'b00});
      end
      m_wp = (m_wp == m_end) ? 8'd0 : m_wp + 8'd1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int w0, l0;
    idle(5);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(ent_ready == 1'b1, "R1", "ent_ready", {31'd0, ent_ready}, 32'd1);
    chk(wr_valid == 1'b0, "R1", "wr_valid", {31'd0, wr_valid}, 32'd0);
    chk(irq == 1'b0, "R1", "irq", {31'd0, irq}, 32'd0);
    reg_rd(3'd4, rd);
    chk(rd == 32'd0, "R1", "write pointer", rd, 32'd0);
    reg_rd(3'd5, rd);
    chk(rd == 32'h1000, "R1", "reload", rd, 32'h1000);
    reg_rd(3'd0, rd);
    chk(rd[0] == 1'b0, "R1", "cache enable", rd, 32'd0);
    idle(1);

    // R5 R6 R8 R9: tiny queue fills, stalls, wraps
    reg_wr(3'd1, 32'h1000_0B00);
    reg_wr(3'd2, 32'd3);
    reg_wr(3'd3, 32'd0);
    for (int i = 0; i < 5; i++) begin
      push(32'h0A00_0000 + i);
      idle(3);
    end
    idle(20);
    chk(writes_seen == 3, "R6", "writes before stall", writes_seen, 3);
    reg_rd(3'd4, rd);
    chk(rd[7:0] == 8'd3, "R5", "wptr at stall", {24'd0, rd[7:0]}, 32'd3);
    chk(rd[31:16] == 16'd3, "R9", "occupancy w>=r", {16'd0, rd[31:16]}, 32'd3);
    idle(1);
    for (int i = 0; i < 6; i++) push(32'h0B00_0000 + i);
    idle(2);
    chk(ent_ready == 1'b0, "R8", "ent_ready with full cache", {31'd0, ent_ready}, 32'd0);
    reg_wr(3'd3, 32'd2);
    idle(20);
    chk(writes_seen == 5, "R6", "writes after host release", writes_seen, 5);
    reg_rd(3'd4, rd);
    chk(rd[7:0] == 8'd1, "R5", "wptr wrapped", {24'd0, rd[7:0]}, 32'd1);
    chk(rd[31:16] == 16'd3, "R9", "occupancy r>w", {16'd0, rd[31:16]}, 32'd3);
    idle(1);
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) begin
      reg_rd(3'd4, rd);
      idle(1);
      reg_wr(3'd3, {24'd0, rd[7:0]});
      idle(12);
    end
    chk(exp_q.size() == 0, "R8", "all entries delivered", exp_q.size(), 0);
    reg_rd(3'd4, rd);
    idle(1);
    reg_wr(3'd3, {24'd0, rd[7:0]});
    reg_wr(3'd2, 32'd255);

    // R7 back-pressure, R2 write-through
    wr_ready = 1'b0;
    push(32'h1234_5678);
    idle(5);
    chk(wr_valid == 1'b1, "R7", "valid held", {31'd0, wr_valid}, 32'd1);
    chk(wr_data == 32'h1234_5678, "R7", "data held", wr_data, 32'h1234_5678);
    idle(3);
    chk(wr_valid == 1'b1 && wr_data == 32'h1234_5678, "R7", "still held", wr_data, 32'h1234_5678);
    wr_ready = 1'b1;
    idle(4);
    w0 = writes_seen; l0 = lasts_seen;
    for (int i = 0; i < 3; i++) push(32'h0C12_0040 + i);
    idle(10);
    chk(writes_seen - w0 == 3, "R2", "write-through count", writes_seen - w0, 3);
    chk(lasts_seen - l0 == 3, "R2", "one last per entry", lasts_seen - l0, 3);

    // R3 watermark of 4
    reg_wr(3'd0, 32'h0000_0041);
    w0 = writes_seen; l0 = lasts_seen;
    for (int i = 0; i < 3; i++) push(32'h0D00_0000 + i);
    idle(10);
    chk(writes_seen == w0, "R3", "held below watermark", writes_seen - w0, 0);
    push(32'h0D00_0003);
    idle(10);
    chk(writes_seen - w0 == 4, "R3", "burst at watermark", writes_seen - w0, 4);
    chk(lasts_seen - l0 == 1, "R3", "single last in burst", lasts_seen - l0, 1);

    // R4 flush timer
    reg_wr(3'd5, 32'd40);
    reg_wr(3'd0, 32'h0000_0081);
    w0 = writes_seen; l0 = lasts_seen;
    for (int i = 0; i < 3; i++) push(32'h0E00_0000 + i);
    idle(20);
    chk(writes_seen == w0, "R4", "no early flush", writes_seen - w0, 0);
    idle(40);
    chk(writes_seen - w0 == 3, "R4", "timer flush", writes_seen - w0, 3);
    chk(lasts_seen - l0 == 1, "R4", "one burst on timeout", lasts_seen - l0, 1);

    // R10 event threshold of 2
    reg_wr(3'd0, 32'h0000_0200);
    reg_wr(3'd6, 32'd1);
    for (int i = 0; i < 2; i++) begin
      push(32'h0F00_0000 + i);
      idle(6);
    end
    reg_rd(3'd6, rd);
    chk(rd[0] == 1'b0 && irq == 1'b0, "R10", "flag after two bursts", {31'd0, irq}, 32'd0);
    idle(1);
    push(32'h0F00_0002);
    idle(6);
    reg_rd(3'd6, rd);
    chk(rd[0] == 1'b1 && irq == 1'b1, "R10", "flag after third burst", {31'd0, irq}, 32'd1);
    idle(1);
    reg_wr(3'd6, 32'd1);
    chk(irq == 1'b0, "R10", "flag cleared", {31'd0, irq}, 32'd0);

    idle(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule